// File: doc/BRIEF.md
# Double-Buffered Peripheral DMA Channel

A single DMA channel that moves a stream of transfer units between system memory and one peripheral FIFO. Two buffer slots, each with its own start address and 16-bit unit count, take turns. While the hardware drains one slot, software can refill the other, so a continuous stream needs no gap for reprogramming. Each slot has its own enable bit and its own done flag.

Software programs the channel through a 32-bit register bus. The mode and status word has two write aliases. A write to offset 0x00 sets every bit written as 1. A write to offset 0x04 clears every bit written as 1. Because of this, individual control bits change without a read-modify-write. Clearing the run bit does not stop the channel at once. The channel finishes any memory beat already in flight and then reports that it has halted. Software waits for that flag before it disables the buffers.

On the memory side the channel issues one request per transfer unit and holds the request until it is acknowledged. The peripheral side has a request/ready pair. The outputs are a done interrupt, a flag that shows which slot is active, and the halted flag.

Top module: `dbdma_channel`

## Requirements
- R1: Mode word bit positions are: 0 slot-0 enable, 1 slot-0 done, 2 slot-1 enable, 3 slot-1 done, 4 active slot, 5 run, 6 halted, 7 interrupt enable, 10:9 unit width (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes), 12 direction (1 = peripheral to memory), 19:16 device tag. A write of 1s to offset 0x00 sets bits 0, 2, 5, 7, 9, 10, 12 and 16..19. A write of 1s to offset 0x04 clears those bits and also bits 1 and 3. Bits 4 and 6 are status only. Unlisted bits read 0. Reads at 0x00 and 0x04 both return the mode word.
- R2: Offset 0x08 holds the peripheral address, which is driven on `per_addr`. Offset 0x0C holds the slot-0 start address, 0x10 the slot-0 count, 0x14 the slot-1 start address and 0x18 the slot-1 count. A count write keeps only bits 15:0. Read data appears on `reg_rdata` one cycle after `reg_rd_en`.
- R3: After reset the mode word reads 0x00000040. `halted` is 1, and `irq`, `active_buf` and `mem_req` are 0.
- R4: A memory beat presents the active slot's current address on `mem_addr` and the direction bit on `mem_we`. `mem_req` and `mem_addr` hold steady until `mem_ack`.
- R5: Each acknowledged beat advances the active slot's address by the unit width in bytes and lowers its count by one.
- R6: When the active slot is enabled with a count of zero while running, its done bit is set and its enable bit is cleared. A hardware update takes priority over a software write to the same bit in the same cycle.
- R7: While running, if the active slot is disabled and the other slot is enabled, the active-slot bit toggles. `active_buf` reads 1 while slot 1 is served.
- R8: `irq` is high exactly when interrupt enable is set and at least one done bit is set. Clearing one done bit leaves `irq` high while the other done bit is still set.
- R9: `halted` is 1 while run is clear and the channel is idle. It falls on the second clock edge after the write that sets run with a slot enabled.
- R10: Clearing run while a beat is in flight leaves `halted` at 0 until `mem_ack` completes that beat. No new beat starts while run is clear.
- R11: A new beat starts only in a cycle where `per_rdy` is high.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid one cycle after the read strobe |
| mem_req | output | 1 | Memory beat request |
| mem_ack | input | 1 | Memory beat acknowledge |
| mem_addr | output | AW | Memory byte address of the beat |
| mem_we | output | 1 | Beat writes memory (peripheral to memory) |
| per_req | output | 1 | Channel wants peripheral service |
| per_rdy | input | 1 | Peripheral can take or give a unit |
| per_addr | output | AW | Programmed peripheral FIFO address |
| irq | output | 1 | Buffer-done interrupt |
| active_buf | output | 1 | Slot currently served |
| halted | output | 1 | Channel has reached a stop point |

## Verification
Several rules are checked on every cycle. A pending memory request keeps its address until it is acknowledged. A halted channel never holds a request open. A beat only begins after a cycle with both ready and run high. A done flag only rises with its enable falling. Each acknowledged beat lowers the slot count by exactly one. Some behaviour can only be shown by the bench scenarios: the full address sequence across a slot switch for 1-, 2- and 4-byte units, the set and clear aliases with their masks, the interrupt that stays high while one done flag remains, the stall with ready low, and the halt that waits for an in-flight beat that is held off.

// File: rtl/dbdma_pkg.sv
package dbdma_pkg;
  localparam int REG_AW = 5;

  localparam logic [REG_AW-1:0] OFF_SET  = 5'h00;
  localparam logic [REG_AW-1:0] OFF_CLR  = 5'h04;
  localparam logic [REG_AW-1:0] OFF_PER  = 5'h08;
  localparam logic [REG_AW-1:0] OFF_S0A  = 5'h0C;
  localparam logic [REG_AW-1:0] OFF_S0C  = 5'h10;
  localparam logic [REG_AW-1:0] OFF_S1A  = 5'h14;
  localparam logic [REG_AW-1:0] OFF_S1C  = 5'h18;

  localparam int B_EN0  = 0;
  localparam int B_DN0  = 1;
  localparam int B_EN1  = 2;
  localparam int B_DN1  = 3;
  localparam int B_ACT  = 4;
  localparam int B_RUN  = 5;
  localparam int B_HLT  = 6;
  localparam int B_IEN  = 7;
  localparam int B_WLO  = 9;
  localparam int B_DIR  = 12;
  localparam int B_TAG  = 16;

  localparam logic [31:0] SET_MASK = 32'h000F_16A5;
  localparam logic [31:0] CLR_MASK = SET_MASK | 32'h0000_000A;

  typedef enum logic {ENG_IDLE, ENG_BEAT} eng_state_t;
endpackage

// File: rtl/dbdma_slot.sv
module dbdma_slot #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_addr,
  input  logic          wr_cnt,
  input  logic [31:0]   wdata,
  input  logic          adv,
  input  logic [2:0]    step,
  output logic [AW-1:0] addr_o,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o <= '0;
      cnt_o  <= '0;
    end else begin
      if (wr_addr)  addr_o <= wdata[AW-1:0];
      else if (adv) addr_o <= addr_o + AW'(step);
      if (wr_cnt)   cnt_o  <= wdata[CW-1:0];
      else if (adv) cnt_o  <= cnt_o - 1'b1;
    end
  end

  // R5
  cnt_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !wr_cnt) |=> (cnt_o == $past(cnt_o) - 1'b1));
endmodule

// File: rtl/dbdma_engine.sv
module dbdma_engine
  import dbdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          act_en,
  input  logic          other_en,
  input  logic [CW-1:0] act_cnt,
  input  logic [AW-1:0] act_addr,
  input  logic          per_rdy,
  input  logic          mem_ack,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          beat_done,
  output logic          finish,
  output logic          swap,
  output logic          per_req,
  output logic          halted
);
  eng_state_t state;
  logic idle, has_work, issue;

  assign idle      = (state == ENG_IDLE);
  assign has_work  = act_en && (act_cnt != '0);
  assign issue     = idle && go && has_work && per_rdy;
  assign finish    = idle && go && act_en && (act_cnt == '0);
  assign swap      = idle && go && !act_en && other_en;
  assign beat_done = (state == ENG_BEAT) && mem_ack;
  assign mem_req   = (state == ENG_BEAT);
  assign per_req   = go && has_work;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ENG_IDLE;
      mem_addr <= '0;
      halted   <= 1'b1;
    end else begin
      if (issue) begin
        state    <= ENG_BEAT;
        mem_addr <= act_addr;
      end else if (beat_done) begin
        state <= ENG_IDLE;
      end
      if (!go && (idle || mem_ack)) halted <= 1'b1;
      else if (go && (act_en || other_en)) halted <= 1'b0;
    end
  end

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
  // R10
  halt_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_req);
  // R11
  req_gated_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> ($past(per_rdy) && $past(go)));
endmodule

// File: rtl/dbdma_channel.sv
module dbdma_channel
  import dbdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  input  logic              mem_ack,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_we,
  output logic              per_req,
  input  logic              per_rdy,
  output logic [AW-1:0]     per_addr,
  output logic              irq,
  output logic              active_buf,
  output logic              halted
);
  localparam int NSLOT = 2;
  localparam logic [REG_AW-1:0] SLOT_A [NSLOT] = '{OFF_S0A, OFF_S1A};
  localparam logic [REG_AW-1:0] SLOT_C [NSLOT] = '{OFF_S0C, OFF_S1C};

  logic [31:0]   mode_q, mode_n;
  logic [AW-1:0] s_addr [NSLOT];
  logic [CW-1:0] s_cnt  [NSLOT];
  logic [2:0]    step;
  logic          ab, beat_done, finish, swap;
  logic          act_en, other_en;

  assign ab       = mode_q[B_ACT];
  assign act_en   = ab ? mode_q[B_EN1] : mode_q[B_EN0];
  assign other_en = ab ? mode_q[B_EN0] : mode_q[B_EN1];

  always_comb begin
    case (mode_q[B_WLO+1:B_WLO])
      2'd0:    step = 3'd1;
      2'd1:    step = 3'd2;
      default: step = 3'd4;
    endcase
  end

  generate
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      dbdma_slot #(.AW(AW), .CW(CW)) i_slot (
        .clk     (clk),
        .rst     (rst),
        .wr_addr (reg_wr_en && reg_addr == SLOT_A[g]),
        .wr_cnt  (reg_wr_en && reg_addr == SLOT_C[g]),
        .wdata   (reg_wdata),
        .adv     (beat_done && (ab == g[0])),
        .step    (step),
        .addr_o  (s_addr[g]),
        .cnt_o   (s_cnt[g])
      );
    end
  endgenerate

  dbdma_engine #(.AW(AW), .CW(CW)) i_engine (
    .clk       (clk),
    .rst       (rst),
    .go        (mode_q[B_RUN]),
    .act_en    (act_en),
    .other_en  (other_en),
    .act_cnt   (s_cnt[ab]),
    .act_addr  (s_addr[ab]),
    .per_rdy   (per_rdy),
    .mem_ack   (mem_ack),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .beat_done (beat_done),
    .finish    (finish),
    .swap      (swap),
    .per_req   (per_req),
    .halted    (halted)
  );

  always_comb begin
    mode_n = mode_q;
    if (reg_wr_en && reg_addr == OFF_SET) mode_n = mode_n | (reg_wdata & SET_MASK);
    if (reg_wr_en && reg_addr == OFF_CLR) mode_n = mode_n & ~(reg_wdata & CLR_MASK);
    if (finish) begin
      mode_n[ab ? B_DN1 : B_DN0] = 1'b1;
      mode_n[ab ? B_EN1 : B_EN0] = 1'b0;
    end
    if (swap) mode_n[B_ACT] = ~ab;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= '0;
      per_addr  <= '0;
      reg_rdata <= '0;
    end else begin
      mode_q <= mode_n;
      if (reg_wr_en && reg_addr == OFF_PER) per_addr <= reg_wdata[AW-1:0];
      if (reg_rd_en) begin
        case (reg_addr)
          OFF_SET, OFF_CLR: begin
            reg_rdata        <= mode_q;
            reg_rdata[B_HLT] <= halted;
          end
          OFF_PER: reg_rdata <= 32'(per_addr);
          OFF_S0A: reg_rdata <= 32'(s_addr[0]);
          OFF_S0C: reg_rdata <= 32'(s_cnt[0]);
          OFF_S1A: reg_rdata <= 32'(s_addr[1]);
          OFF_S1C: reg_rdata <= 32'(s_cnt[1]);
          default: reg_rdata <= '0;
        endcase
      end
    end
  end

  assign mem_we     = mode_q[B_DIR];
  assign active_buf = ab;
  assign irq        = mode_q[B_IEN] && (mode_q[B_DN0] || mode_q[B_DN1]);

  // R6
  done0_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_q[B_DN0]) |-> !mode_q[B_EN0]);
  // R6
  done1_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_q[B_DN1]) |-> !mode_q[B_EN1]);
endmodule

// File: tb/test_dbdma_channel.sv
module test_dbdma_channel;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_req, mem_ack = 1'b0, mem_we, per_req, per_rdy = 1'b1;
  logic [31:0] mem_addr, per_addr;
  logic        irq, active_buf, halted;

  int n_cmp = 0, n_bad = 0;
  logic ack_hold = 1'b0;
  logic [32:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dbdma_channel i_dbdma_channel (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_we(mem_we),
    .per_req(per_req), .per_rdy(per_rdy), .per_addr(per_addr), .irq(irq),
    .active_buf(active_buf), .halted(halted)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic push_beat(input logic we, input logic [31:0] a);
    exp_q.push_back({we, a});
  endtask

  // monitor: acks beats and compares them against the scoreboard
  always @(negedge clk) begin
    if (rst) mem_ack = 1'b0;
    else if (mem_req && !ack_hold) begin
      mem_ack = 1'b1;
      if (exp_q.size() == 0) chk("R4 unexpected beat", mem_addr, 32'hFFFF_FFFF);
      else begin
        logic [32:0] e;
        e = exp_q.pop_front();
        chk("R4 R5 beat addr", mem_addr, e[31:0]);
        chk("R4 beat dir", 32'(mem_we), 32'(e[32]));
      end
    end else mem_ack = 1'b0;
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (6) @(negedge clk);
    chk("R4 scoreboard empty", 32'(exp_q.size()), 32'd0);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R3 reset state
    rd(5'h00, d); chk("R3 mode reset", d, 32'h40);
    chk("R3 halted", 32'(halted), 1); chk("R3 irq", 32'(irq), 0);
    chk("R3 mem_req", 32'(mem_req), 0); chk("R3 active_buf", 32'(active_buf), 0);

    // R2 register map
    wr(5'h08, 32'hA000_0040); wr(5'h0C, 32'h0000_1000); wr(5'h10, 32'h0001_2345);
    wr(5'h14, 32'h0000_2000); wr(5'h18, 32'h0000_0002);
    rd(5'h08, d); chk("R2 peripheral addr", d, 32'hA000_0040);
    chk("R2 per_addr port", per_addr, 32'hA000_0040);
    rd(5'h0C, d); chk("R2 slot0 start", d, 32'h1000);
    rd(5'h10, d); chk("R2 slot0 count masked", d, 32'h2345);
    rd(5'h14, d); chk("R2 slot1 start", d, 32'h2000);

    // R1 set/clear aliases (run left clear)
    wr(5'h00, 32'hFFFF_FFDF);
    rd(5'h00, d); chk("R1 set mask", d, 32'h000F_16C5);
    rd(5'h04, d); chk("R1 read at clear alias", d, 32'h000F_16C5);
    wr(5'h04, 32'hFFFF_FFFF);
    rd(5'h00, d); chk("R1 clear all", d, 32'h40);

    // R4..R9 two-slot run, 4-byte units, peripheral to memory
    wr(5'h10, 32'h3);
    push_beat(1, 32'h1000); push_beat(1, 32'h1004); push_beat(1, 32'h1008);
    push_beat(1, 32'h2000); push_beat(1, 32'h2004);
    wr(5'h00, 32'h0000_1485);
    wr(5'h00, 32'h20);
    chk("R9 halted one edge after run", 32'(halted), 1);
    @(negedge clk);
    chk("R9 halted falls", 32'(halted), 0);
    drain();
    rd(5'h00, d); chk("R6 R7 mode after both slots", d, 32'h0000_14BA);
    chk("R7 active_buf slot1", 32'(active_buf), 1);
    chk("R8 irq both done", 32'(irq), 1);
    rd(5'h18, d); chk("R5 slot1 count", d, 32'h0);
    rd(5'h14, d); chk("R5 slot1 addr", d, 32'h2008);
    rd(5'h0C, d); chk("R5 slot0 addr", d, 32'h100C);
    wr(5'h04, 32'h2);
    chk("R8 irq one done left", 32'(irq), 1);
    wr(5'h04, 32'h8);
    chk("R8 irq none done", 32'(irq), 0);

    // R11 + 2-byte units, memory to peripheral
    wr(5'h04, 32'h20);
    repeat (2) @(negedge clk);
    chk("R9 halted after run clear", 32'(halted), 1);
    wr(5'h04, 32'h1600); wr(5'h00, 32'h200);
    wr(5'h0C, 32'h3000); wr(5'h10, 32'h2);
    per_rdy = 1'b0;
    wr(5'h00, 32'h1); wr(5'h00, 32'h20);
    repeat (10) @(negedge clk);
    chk("R11 no beat without ready", 32'(mem_req), 0);
    rd(5'h10, d); chk("R11 count untouched", d, 32'h2);
    push_beat(0, 32'h3000); push_beat(0, 32'h3002);
    per_rdy = 1'b1;
    drain();
    chk("R7 active_buf back to slot0", 32'(active_buf), 0);
    rd(5'h00, d); chk("R6 mode after slot0", d, 32'h0000_02A2);
    wr(5'h04, 32'h2);

    // R10 stop waits for in-flight beat, 1-byte units
    wr(5'h04, 32'h20);
    repeat (2) @(negedge clk);
    wr(5'h04, 32'h600);
    wr(5'h0C, 32'h4000); wr(5'h10, 32'h5);
    ack_hold = 1'b1;
    push_beat(0, 32'h4000);
    wr(5'h00, 32'h1); wr(5'h00, 32'h20);
    for (int i = 0; i < 50 && !mem_req; i++) @(negedge clk);
    wr(5'h04, 32'h20);
    repeat (5) @(negedge clk);
    chk("R10 not halted during beat", 32'(halted), 0);
    chk("R10 beat held", 32'(mem_req), 1);
    @(posedge clk);
    ack_hold = 1'b0;
    repeat (6) @(negedge clk);
    chk("R10 halted after beat", 32'(halted), 1);
    chk("R10 no further beat", 32'(mem_req), 0);
    rd(5'h10, d); chk("R10 count after one beat", d, 32'h4);
    rd(5'h0C, d); chk("R5 byte step", d, 32'h4001);
    chk("R10 scoreboard empty", 32'(exp_q.size()), 32'd0);

    finish_run();
  end
endmodule